// File: doc/BRIEF.md
# I2C serial EEPROM slave controller

This block is a synthesizable two-wire bus slave. It makes an on-chip byte store behave like a serial EEPROM. SCL and SDA are oversampled on the system clock and pass through a synchronizer. The slave never drives the bus high. It only raises an open-drain enable, `sda_oe`, that pulls SDA low. A transfer starts with a select byte. A write then carries a two-byte address, most significant byte first, followed by data bytes. The data bytes collect in a 128-entry page buffer and are committed at Stop. A timed programming window follows the commit. During that window the slave ignores every select byte, so a master can poll until one is acknowledged. Reads return the byte at an internal address counter and step that counter. A dummy write followed by a repeated Start turns this into a random read.

The select byte is sent MSB first: type code in bits 7..4, chip-enable match in bits 3..1, read flag in bit 0. Type `1010` reaches the main array. Type `1011` reaches a separate 128-byte identification page. The identification page can be locked for good. A write-control input can refuse data bytes without disturbing the rest of the transfer. The array depth (`ADDR_W`) and the programming time (`WRITE_CYCLES`) are parameters.

The controller is a single state machine:
- `S_IDLE` waits for a Start.
- `S_DEVSEL` shifts in the select byte. It moves to `S_DEV_ACK` on a match, otherwise to `S_IGNORE`.
- `S_DEV_ACK` moves to `S_RDATA` for a read, or to `S_ADDR_HI` for a write.
- The address bytes go through `S_ADDR_HI`, `S_HI_ACK`, `S_ADDR_LO` and `S_LO_ACK`, then to `S_WDATA`.
- `S_WDATA` moves to `S_DATA_ACK` when it accepts a byte, and from there back to `S_WDATA`. A refused byte sends it to `S_IGNORE`.
- `S_RDATA` shifts out 8 bits and then moves to `S_RD_ACK`. There, a master acknowledge returns to `S_RDATA`, and a missing acknowledge goes to `S_IGNORE`.
- A Start forces `S_DEVSEL` from any state. A Stop forces `S_IDLE` from any state.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A select byte is acknowledged only when bits 7..4 are `1010` (array) or `1011` (identification page), bits 3..1 equal `chip_en`, and no write cycle is running. Bits arrive MSB first. After a mismatch, SDA stays released until the next Start or Stop.
- R2: A write sends the high address byte, then the low address byte. The byte address is the low `ADDR_W` bits of that 16-bit value, so higher bits alias.
- R3: After each accepted data byte, only address bits 6..0 step. A page write past byte 127 of a page wraps to byte 0 of the same page.
- R4: While `wr_ctrl` is 1, select and address bytes are still acknowledged. Data bytes get no acknowledge, nothing is programmed, and no write cycle starts.
- R5: A Stop after at least one accepted data byte programs the buffered bytes and starts a write cycle of `WRITE_CYCLES` clocks, during which no select byte is acknowledged. A Stop with no accepted data starts no cycle.
- R6: A read select without an address phase returns the byte at the internal counter and then increments the counter.
- R7: A dummy write (select plus two address bytes), then a repeated Start and a read select, reads from the loaded address.
- R8: After each read byte the slave samples bit slot 9. Low continues with the next address. High ends the read, with SDA released.
- R9: After reset every array and identification-page byte reads `FFh`.
- R10: Type `1011` reads and writes the identification page, indexed by address bits 6..0, without touching the array.
- R11: An identification-page write with address bit 15 set and one accepted data byte locks the page at Stop, without programming data. From then on, identification-page data bytes are refused and the page keeps its contents until reset.
- R12: A Start or Stop at any point aborts the transfer and clears the bit counter. A Start drops unprogrammed buffered data.
- R13: `sda_oe` is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| chip_en | input | 3 | Strap value compared with select bits 3..1 |
| wr_ctrl | input | 1 | High refuses all data bytes of writes |
| sda_oe | output | 1 | High pulls SDA low (open drain) |

## Verification
A corrupted state, bit count or address counter shows at the ports within one byte slot. It appears as an acknowledge missing from the 9th slot, or one that should not be there, or as wrong data on the next read. Page wrap, address aliasing and lock are checked by writing, polling until the slave answers, and reading back. The write-cycle window is checked by requiring that the first poll after a Stop is refused. The same poll must be accepted at once when no data was committed. Aborts are checked by the absence of programming after a Start or Stop lands mid-transfer.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
    localparam int EEP_PAGE_W = 7;
    localparam logic [3:0] TYPE_ARRAY = 4'b1010;
    localparam logic [3:0] TYPE_IDPG  = 4'b1011;

    typedef enum logic [3:0] {
        S_IDLE, S_DEVSEL, S_DEV_ACK, S_ADDR_HI, S_HI_ACK, S_ADDR_LO,
        S_LO_ACK, S_WDATA, S_DATA_ACK, S_RDATA, S_RD_ACK, S_IGNORE
    } eep_state_t;
endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          remain <= '0;
        else if (start)      remain <= CW'(CYCLES);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R5
    timer_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/eeprom_storage.sv
module eeprom_storage #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic                          commit_id,
    input  logic                          commit_lock,
    input  logic [ADDR_W-PAGE_W-1:0]      page_idx,
    input  logic [(1<<PAGE_W)-1:0][7:0]   wr_buf,
    input  logic [(1<<PAGE_W)-1:0]        wr_mask,
    input  logic                          rd_id,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_byte,
    output logic                          locked
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PBYTES = 1 << PAGE_W;

    logic [7:0] arr [DEPTH];
    logic [7:0] idp [PBYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)  arr[i] <= 8'hFF;
            for (int i = 0; i < PBYTES; i++) idp[i] <= 8'hFF;
            locked <= 1'b0;
        end else if (commit) begin
            if (commit_id && commit_lock) begin
                locked <= 1'b1;
            end else if (commit_id) begin
                for (int i = 0; i < PBYTES; i++)
                    if (wr_mask[i]) idp[i] <= wr_buf[i];
            end else begin
                for (int i = 0; i < PBYTES; i++)
                    if (wr_mask[i]) arr[{page_idx, PAGE_W'(i)}] <= wr_buf[i];
            end
        end
    end

    assign rd_byte = rd_id ? idp[rd_addr[PAGE_W-1:0]] : arr[rd_addr];

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> locked);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int WRITE_CYCLES = 400,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_en,
    input  logic       wr_ctrl,
    output logic       sda_oe
);
    localparam int PAGE_W = EEP_PAGE_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    eep_state_t state, state_n;
    logic [3:0]  cnt;
    logic [7:0]  sh, addr_hi, rd_byte;
    logic [15:0] addr;
    logic id_sel, rw, lock_req, pend, busy, locked, oe_q;
    logic [PAGE_BYTES-1:0][7:0] pbuf;
    logic [PAGE_BYTES-1:0]      pmask;
    logic byte_done, receiving, sel_ok, accept, load_rd, commit;

    eeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
    );

    eeprom_storage #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_id(id_sel),
        .commit_lock(lock_req), .page_idx(addr[ADDR_W-1:PAGE_W]),
        .wr_buf(pbuf), .wr_mask(pmask), .rd_id(id_sel),
        .rd_addr(addr[ADDR_W-1:0]), .rd_byte(rd_byte), .locked(locked)
    );

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign receiving = (state == S_DEVSEL) || (state == S_ADDR_HI) ||
                       (state == S_ADDR_LO) || (state == S_WDATA);
    assign sel_ok    = ((sh[7:4] == TYPE_ARRAY) || (sh[7:4] == TYPE_IDPG)) &&
                       (sh[3:1] == chip_en) && !busy;
    assign accept    = !wr_ctrl && !(id_sel && locked);
    assign load_rd   = scl_fall && (((state == S_DEV_ACK) && rw) || (state == S_RD_ACK));
    assign commit    = stop_det && pend;

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = S_DEVSEL;
        end else if (stop_det) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_DEVSEL:   if (byte_done) state_n = sel_ok ? S_DEV_ACK : S_IGNORE;
                S_DEV_ACK:  if (scl_fall)  state_n = rw ? S_RDATA : S_ADDR_HI;
                S_ADDR_HI:  if (byte_done) state_n = S_HI_ACK;
                S_HI_ACK:   if (scl_fall)  state_n = S_ADDR_LO;
                S_ADDR_LO:  if (byte_done) state_n = S_LO_ACK;
                S_LO_ACK:   if (scl_fall)  state_n = S_WDATA;
                S_WDATA:    if (byte_done) state_n = accept ? S_DATA_ACK : S_IGNORE;
                S_DATA_ACK: if (scl_fall)  state_n = S_WDATA;
                S_RDATA:    if (scl_fall && cnt == 4'd7) state_n = S_RD_ACK;
                S_RD_ACK: begin
                    if (scl_rise && sda_s) state_n = S_IGNORE;
                    else if (scl_fall)     state_n = S_RDATA;
                end
                S_IDLE, S_IGNORE: state_n = state;
                default:          state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // datapath: bit counter, shifter, address counter, page buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sh <= '0; addr <= '0; addr_hi <= '0;
            id_sel <= 1'b0; rw <= 1'b0; lock_req <= 1'b0; pend <= 1'b0;
            pbuf <= '0; pmask <= '0;
        end else begin
            if (start_det || stop_det || state_n != state) cnt <= '0;
            else if (scl_rise && receiving)                 cnt <= cnt + 1'b1;
            else if (scl_fall && state == S_RDATA)          cnt <= cnt + 1'b1;

            if (scl_rise && receiving)                       sh <= {sh[6:0], sda_s};
            else if (load_rd)                                sh <= rd_byte;
            else if (scl_fall && state == S_RDATA && cnt != 4'd7) sh <= {sh[6:0], 1'b0};

            if (byte_done && state == S_DEVSEL) begin
                id_sel <= sh[4];
                rw     <= sh[0];
            end
            if (byte_done && state == S_ADDR_HI) addr_hi <= sh;

            if (start_det || commit) begin
                pend <= 1'b0;
            end else if (byte_done && state == S_ADDR_LO) begin
                addr     <= {addr_hi, sh};
                lock_req <= addr_hi[7];
                pmask    <= '0;
                pend     <= 1'b0;
            end else if (byte_done && state == S_WDATA) begin
                pend <= accept;
                if (accept) begin
                    pbuf[addr[PAGE_W-1:0]]  <= sh;
                    pmask[addr[PAGE_W-1:0]] <= 1'b1;
                    addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
                end
            end else if (load_rd) begin
                addr <= addr + 1'b1;
            end
        end
    end

    // output register: open-drain pull enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (start_det || stop_det) begin
            oe_q <= 1'b0;
        end else if (scl_fall) begin
            unique case (state)
                S_DEVSEL:             oe_q <= (cnt == 4'd8) && sel_ok;
                S_ADDR_HI, S_ADDR_LO: oe_q <= (cnt == 4'd8);
                S_WDATA:              oe_q <= (cnt == 4'd8) && accept;
                S_DEV_ACK:            oe_q <= rw && !rd_byte[7];
                S_RD_ACK:             oe_q <= !rd_byte[7];
                S_RDATA:              oe_q <= (cnt != 4'd7) && !sh[6];
                default:              oe_q <= 1'b0;
            endcase
        end
    end

    assign sda_oe = oe_q;

    // R13
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));
    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == S_DEVSEL && byte_done) |=> !sda_oe);
    // R4
    wc_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && state == S_WDATA && byte_done) |=> !sda_oe);
    // R12
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_DEVSEL && cnt == 4'd0));
    // R3
    page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WDATA && byte_done && accept) |=>
            (addr[15:PAGE_W] == $past(addr[15:PAGE_W])));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb;
    localparam int Q = 4;
    localparam logic [2:0] CE = 3'b101;
    // {address[15:0], data[7:0]}
    localparam logic [23:0] VEC [7] = '{
        24'h0000A5, 24'h01233C, 24'h03FF81, 24'h02805A,
        24'h007FC3, 24'h0355E7, 24'h5C106E
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, wrc = 1'b0;
    logic sda_oe;
    logic line;
    int checks = 0, fails = 0, viol = 0;
    bit done = 1'b0;

    assign line = m_sda & ~sda_oe;
    always #2.5 clk = ~clk;

    i2c_eeprom_slave #(.ADDR_W(10), .WRITE_CYCLES(400), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
        .chip_en(CE), .wr_ctrl(wrc), .sda_oe(sda_oe)
    );

    always @(posedge sda_oe) if (scl === 1'b1) viol++;

    task automatic tick(input int k); repeat (k) @(negedge clk); endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        tick(Q); m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    endtask
    task automatic read_bit(output logic b);
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = line; tick(Q); scl = 1'b0;
    endtask
    task automatic bus_start();
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
    endtask
    task automatic bus_stop();
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask
    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(a);
        ack = !a;
    endtask
    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
        send_bit(!give_ack);
    endtask
    function automatic logic [7:0] sel(input logic id, input logic rd);
        return {id ? 4'b1011 : 4'b1010, CE, rd};
    endfunction
    task automatic open_write(input logic id, input logic [15:0] a, output logic ok);
        logic a0, a1, a2;
        bus_start();
        send_byte(sel(id, 1'b0), a0);
        send_byte(a[15:8], a1);
        send_byte(a[7:0], a2);
        ok = a0 & a1 & a2;
    endtask
    task automatic byte_write(input logic id, input logic [15:0] a, input logic [7:0] d,
                              output logic dack);
        logic ok;
        open_write(id, a, ok);
        send_byte(d, dack);
        bus_stop();
    endtask
    task automatic poll(output int n);
        logic ak;
        n = 0; ak = 1'b0;
        while (!ak && n < 40) begin
            n++;
            bus_start();
            send_byte(sel(1'b0, 1'b0), ak);
            bus_stop();
        end
    endtask
    task automatic rand_read(input logic id, input logic [15:0] a, output logic [7:0] v);
        logic ok, ak;
        open_write(id, a, ok);
        bus_start();
        send_byte(sel(id, 1'b1), ak);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        logic ok, ak, dack;
        logic [7:0] b, b0, b1, b2;
        int n;
        tick(5); rst_n = 1'b1; tick(5);

        chk("R9 reset releases SDA", sda_oe, 1'b0);
        rand_read(1'b0, 16'h0200, b);
        chk("R9 array powers up FF", b, 8'hFF);

        // vector table: byte write, poll, random read back
        for (int v = 0; v < 7; v++) begin
            byte_write(1'b0, VEC[v][23:8], VEC[v][7:0], dack);
            chk("R2 data byte acked", dack, 1'b1);
            poll(n);
            chk("R5 first poll refused during write cycle", n > 1, 1'b1);
            rand_read(1'b0, VEC[v][23:8], b);
            chk("R7 random read returns written byte", b, VEC[v][7:0]);
        end
        rand_read(1'b0, 16'h0010, b);
        chk("R2 upper address bits alias", b, 8'h6E);

        // R1 select decode
        bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, ak);
        chk("R1 wrong chip enable not acked", ak, 1'b0);
        send_byte(8'h00, ak);
        chk("R1 silent after mismatch", ak, 1'b0);
        bus_stop();
        bus_start(); send_byte({4'b1001, CE, 1'b0}, ak); bus_stop();
        chk("R1 wrong type not acked", ak, 1'b0);

        // R3 page wrap and R8 sequential read
        open_write(1'b0, 16'h017E, ok);
        send_byte(8'h11, ak); send_byte(8'h22, ak);
        send_byte(8'h33, ak); send_byte(8'h44, ak);
        bus_stop();
        poll(n);
        open_write(1'b0, 16'h017E, ok);
        bus_start(); send_byte(sel(1'b0, 1'b1), ak);
        recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b0, b2);
        bus_stop();
        chk("R8 sequential byte 0", b0, 8'h11);
        chk("R8 sequential byte 1", b1, 8'h22);
        chk("R3 no write past page end", b2, 8'hFF);
        rand_read(1'b0, 16'h0100, b);
        chk("R3 wrapped to page start", b, 8'h33);
        bus_start(); send_byte(sel(1'b0, 1'b1), ak); recv_byte(1'b0, b); bus_stop();
        chk("R6 current address read", b, 8'h44);

        // R4 write control
        wrc = 1'b1;
        open_write(1'b0, 16'h0050, ok);
        chk("R4 select and address acked", ok, 1'b1);
        send_byte(8'h77, dack);
        chk("R4 data refused", dack, 1'b0);
        bus_stop();
        wrc = 1'b0;
        poll(n);
        chk("R4 no write cycle", n, 1);
        rand_read(1'b0, 16'h0050, b);
        chk("R4 nothing programmed", b, 8'hFF);

        // R5 stop without data
        open_write(1'b0, 16'h0060, ok); bus_stop();
        poll(n);
        chk("R5 empty write starts no cycle", n, 1);

        // R12 aborts
        open_write(1'b0, 16'h0300, ok);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        poll(n);
        chk("R12 stop mid-byte starts no cycle", n, 1);
        rand_read(1'b0, 16'h0300, b);
        chk("R12 partial byte not programmed", b, 8'hFF);
        open_write(1'b0, 16'h0301, ok);
        send_byte(8'h42, ak);
        bus_start(); bus_stop();
        poll(n);
        chk("R12 start drops buffered data", n, 1);
        rand_read(1'b0, 16'h0301, b);
        chk("R12 dropped byte not programmed", b, 8'hFF);

        // R10 identification page
        byte_write(1'b1, 16'h0005, 8'h9E, dack);
        chk("R10 id data acked", dack, 1'b1);
        poll(n);
        rand_read(1'b1, 16'h0005, b);
        chk("R10 id page readback", b, 8'h9E);
        rand_read(1'b0, 16'h0005, b);
        chk("R10 array untouched", b, 8'hFF);

        // R11 lock
        byte_write(1'b1, 16'h8000, 8'h02, dack);
        chk("R11 lock byte acked", dack, 1'b1);
        poll(n);
        chk("R11 lock runs a write cycle", n > 1, 1'b1);
        byte_write(1'b1, 16'h0006, 8'h55, dack);
        chk("R11 locked page refuses data", dack, 1'b0);
        poll(n);
        rand_read(1'b1, 16'h0006, b);
        chk("R11 locked page unchanged", b, 8'hFF);
        rand_read(1'b1, 16'h0000, b);
        chk("R11 lock command writes no data", b, 8'hFF);
        rand_read(1'b1, 16'h0005, b);
        chk("R11 locked page still readable", b, 8'h9E);

        chk("R13 SDA pulled only while SCL low", viol, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule